// File: doc/BRIEF.md
# Display Data Channel Bit-Bang GPIO Register

This block is a 32-bit memory-mapped register that lets software drive a two-wire display data channel (a clock line and a data line in I2C style) one bit at a time. Each line has an enable bit and a drive bit. An enabled line with a drive bit of 0 is pulled low through an open-drain pad. Any other line is released and floats high through the board pull-up. The levels actually present on the wires come back through a synchroniser. They land in two read-back bits, so software sees the resolved bus, including a device on the far end holding the data line low.

All field positions are offsets from a parameter `BIT_BASE` (B):

| Bit | Function |
| --- | --- |
| B | data drive |
| B+1 | clock drive |
| B+16 | data enable |
| B+17 | clock enable |
| B+8 | data read-back |
| B+9 | clock read-back |

In the plain variant (`MASKED=0`), every register write updates the wires. In the masked variant (`MASKED=1`), software may write single byte lanes. A write updates the wires only when the mask bit (`MASK_BIT`, default 25) of the merged value is set and one of two things holds:

- the write covers the byte lane holding the enable bits, or
- the write covers the byte lane holding the drive bits while at least one enable bit is set.

After an update, a small sequencer waits for the synchroniser to settle and then captures the wire levels.

The sequencer has three states:

- **SEQ_IDLE**: nothing pending. On an update it moves to SEQ_SETTLE (the *launch* transition).
- **SEQ_SETTLE**: counts `SETTLE_CYCLES`. When the count ends it moves to SEQ_CAPTURE (*settled*). A new update in this state restarts the count (*restart*).
- **SEQ_CAPTURE**: clears bits 11:8 and writes the two read-back bits. It then returns to SEQ_IDLE (*done*). If a new update arrives in this state, the capture is dropped and the sequencer goes back to SEQ_SETTLE (*preempt*).

`BIT_BASE` must be 0 to 2, so that both read-back bits fall inside bits 11:8.

Top module: `ddc_gpio_reg`

## Requirements
- R1: After reset the register reads 0x00000000 and both pad pull-down outputs are 0 (lines released).
- R2: After an update, a pad pull-down output is 1 exactly when its enable bit (B+16 data, B+17 clock) is 1 and its drive bit (B data, B+1 clock) is 0.
- R3: A released line with nothing else pulling it reads back as 1 in its read-back bit (B+8 data, B+9 clock).
- R4: The read-back bits carry the resolved wire level: an external device holding data low makes bit B+8 read 0 even when the master releases data.
- R5: Each capture clears register bits 11:8 before setting the read-back bits, discarding any value software wrote there.
- R6: With the default two-stage synchroniser and SETTLE_CYCLES=2, new read-back values become visible three clock edges after the edge that took the updating write, and not earlier.
- R7: Reads return the full 32-bit stored value. A write changes only the byte lanes whose byte enables are set.
- R8: With MASKED=0, every write updates the pads and starts a capture.
- R9: With MASKED=1, a write that leaves the mask bit (bit 25) clear changes neither the pads nor the read-back bits, even if it covers the enable lane.
- R10: With MASKED=1 and the mask bit set, a write covering the enable byte lane (lane 2 for B=1) updates the pads and the read-back bits.
- R11: With MASKED=1 and the mask bit set, a write covering only the drive byte lane (lane 0) updates only while an enable bit is 1. A write to any other lane combination that misses both lanes does not update.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Stored register value |
| ddc_clk_wire | input | 1 | Level sensed on the clock wire |
| ddc_dat_wire | input | 1 | Level sensed on the data wire |
| ddc_clk_pull | output | 1 | 1 pulls the clock wire low (open-drain) |
| ddc_dat_pull | output | 1 | 1 pulls the data wire low (open-drain) |

## Verification
The bench builds two copies side by side. The first uses BIT_BASE=1 with the mask rule on. A table walk drives it through the mask and lane gating, lane-0 updates with and without enables set, and partial lane merges. The second uses BIT_BASE=0 with the rule off, which exposes the every-write update path and lets the exact capture latency be observed cycle by cycle. A modelled pull-up and a device that can hold data low reach the resolved-wire read-back on both copies.

// File: rtl/ddc_gpio_pkg.sv
package ddc_gpio_pkg;

    localparam int REG_W = 32;
    localparam int LANES = REG_W / 8;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_SETTLE  = 2'd1,
        SEQ_CAPTURE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out
);

    logic [STAGES-1:0] chain_q;

    // Flops reset high: a released, pulled-up line idles at 1
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b1;
                else        chain_q[0] <= level_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b1;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign level_out = chain_q[STAGES-1];

endmodule

// File: rtl/ddc_update_qual.sv
module ddc_update_qual #(
    parameter bit MASKED = 1'b0
) (
    input  logic wr_en,
    input  logic mask_set,
    input  logic enable_any,
    input  logic en_lane_hit,
    input  logic drv_lane_hit,
    output logic update
);

    logic masked_ok;

    always_comb begin
        masked_ok = mask_set && (en_lane_hit || (drv_lane_hit && enable_any));
        update    = wr_en && (!MASKED || masked_ok);
    end

endmodule

// File: rtl/ddc_seq_fsm.sv
module ddc_seq_fsm
    import ddc_gpio_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic update,
    output logic capture
);

    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    seq_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (update) begin
                    state_d = SEQ_SETTLE;
                    cnt_d   = '0;
                end
            end
            SEQ_SETTLE: begin
                if (update) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = SEQ_CAPTURE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SEQ_CAPTURE: begin
                if (update) begin
                    state_d = SEQ_SETTLE;
                    cnt_d   = '0;
                end else begin
                    state_d = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        capture = (state_q == SEQ_CAPTURE) && !update;
    end

    // R6: a capture is only reached after the settle wait
    a_r6_capture_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_CAPTURE) |-> ($past(state_q) == SEQ_SETTLE));

    // R6: an update always lands the sequencer in the settle state
    a_r6_update_starts_settle: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (state_q == SEQ_SETTLE));

endmodule

// File: rtl/ddc_gpio_reg.sv
module ddc_gpio_reg
    import ddc_gpio_pkg::*;
#(
    parameter int BIT_BASE      = 0,
    parameter bit MASKED        = 1'b0,
    parameter int MASK_BIT      = 25,
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        ddc_clk_wire,
    input  logic        ddc_dat_wire,
    output logic        ddc_clk_pull,
    output logic        ddc_dat_pull
);

    localparam int DAT_DRV = BIT_BASE;
    localparam int CLK_DRV = BIT_BASE + 1;
    localparam int DAT_RB  = BIT_BASE + 8;
    localparam int CLK_RB  = BIT_BASE + 9;
    localparam int DAT_EN  = BIT_BASE + 16;
    localparam int CLK_EN  = BIT_BASE + 17;
    localparam int EN_LANE  = DAT_EN / 8;
    localparam int DRV_LANE = DAT_DRV / 8;

    logic [REG_W-1:0] reg_q, reg_d, merged;
    logic clk_pull_q, dat_pull_q;
    logic clk_sync, dat_sync;
    logic update, capture;

    // Byte-lane merge of the incoming write
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[8*i +: 8] = wr_be[i] ? wr_data[8*i +: 8] : reg_q[8*i +: 8];
    end

    ddc_update_qual #(
        .MASKED (MASKED)
    ) u_qual (
        .wr_en        (wr_en),
        .mask_set     (merged[MASK_BIT]),
        .enable_any   (merged[DAT_EN] | merged[CLK_EN]),
        .en_lane_hit  (wr_be[EN_LANE]),
        .drv_lane_hit (wr_be[DRV_LANE]),
        .update       (update)
    );

    ddc_line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (ddc_clk_wire),
        .level_out (clk_sync)
    );

    ddc_line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (ddc_dat_wire),
        .level_out (dat_sync)
    );

    ddc_seq_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .update  (update),
        .capture (capture)
    );

    // Register contents: write merge first, capture overrides the nibble
    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            reg_d = merged;
        end
        if (capture) begin
            reg_d[11:8]   = 4'h0;
            reg_d[CLK_RB] = clk_sync;
            reg_d[DAT_RB] = dat_sync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    // Pad pull-downs change only on a qualified update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_pull_q <= 1'b0;
            dat_pull_q <= 1'b0;
        end else if (update) begin
            clk_pull_q <= merged[CLK_EN] & ~merged[CLK_DRV];
            dat_pull_q <= merged[DAT_EN] & ~merged[DAT_DRV];
        end
    end

    assign rd_data      = reg_q;
    assign ddc_clk_pull = clk_pull_q;
    assign ddc_dat_pull = dat_pull_q;

    // R2: after an update the pads follow the stored enable and drive bits
    a_r2_pads_follow_fields: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (ddc_clk_pull == (rd_data[CLK_EN] && !rd_data[CLK_DRV]))
               && (ddc_dat_pull == (rd_data[DAT_EN] && !rd_data[DAT_DRV])));

    // R9: without an update the pads hold
    a_r9_pads_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable({ddc_clk_pull, ddc_dat_pull}));

    // R5: a capture leaves only the two read-back bits possibly set in 11:8
    a_r5_nibble_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ((rd_data[11:8] & ~(4'b0011 << BIT_BASE)) == 4'h0));

    // R4: captured read-back equals the synchronised wire level
    a_r4_readback_wire: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (rd_data[DAT_RB] == $past(dat_sync))
                 && (rd_data[CLK_RB] == $past(clk_sync)));

endmodule

// File: tb/sim_ddc_gpio_reg.sv
module sim_ddc_gpio_reg;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // copy u0: BIT_BASE=1, masked; copy u1: BIT_BASE=0, plain
    logic        we0, we1;
    logic [3:0]  be0, be1;
    logic [31:0] wd0, wd1, rd0, rd1;
    logic        cp0, dp0, cp1, dp1;
    logic        hold0 = 1'b0, hold1 = 1'b0;
    wire         cw0 = ~cp0;
    wire         dw0 = ~dp0 & ~hold0;
    wire         cw1 = ~cp1;
    wire         dw1 = ~dp1 & ~hold1;

    ddc_gpio_reg #(.BIT_BASE(1), .MASKED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(we0), .wr_be(be0), .wr_data(wd0),
        .rd_data(rd0), .ddc_clk_wire(cw0), .ddc_dat_wire(dw0),
        .ddc_clk_pull(cp0), .ddc_dat_pull(dp0));

    ddc_gpio_reg #(.BIT_BASE(0), .MASKED(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(we1), .wr_be(be1), .wr_data(wd1),
        .rd_data(rd1), .ddc_clk_wire(cw1), .ddc_dat_wire(dw1),
        .ddc_clk_pull(cp1), .ddc_dat_pull(dp1));

    typedef struct packed {
        logic [3:0]  be;
        logic [31:0] data;
        logic        hold;
        logic [1:0]  pads;   // {clk pull, dat pull}
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{4'b1111, 32'h0006_0000, 1'b0, 2'b00, 32'h0006_0000},  // R9 mask clear
        '{4'b1111, 32'h0206_0000, 1'b0, 2'b11, 32'h0206_0000},  // R10 R2 both low
        '{4'b0001, 32'h0000_0006, 1'b0, 2'b00, 32'h0206_0606},  // R11 lane0 enables on
        '{4'b0001, 32'h0000_0006, 1'b1, 2'b00, 32'h0206_0406},  // R4 held data
        '{4'b0100, 32'h0000_0000, 1'b0, 2'b00, 32'h0200_0606},  // R3 R10 released
        '{4'b0001, 32'h0000_0000, 1'b0, 2'b00, 32'h0200_0600},  // R11 no enables
        '{4'b1000, 32'h0000_0000, 1'b0, 2'b00, 32'h0000_0600},  // R11 lane3 only
        '{4'b0100, 32'h0004_0000, 1'b0, 2'b00, 32'h0004_0600},  // R9 mask clear
        '{4'b1100, 32'h0204_0000, 1'b0, 2'b10, 32'h0204_0200},  // R2 clock low
        '{4'b0010, 32'h0000_FF00, 1'b0, 2'b10, 32'h0204_FF00},  // R7 lane1 only
        '{4'b0101, 32'h0004_0004, 1'b0, 2'b00, 32'h0204_F604}   // R5 nibble
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit which, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        if (which) begin we1 = 1'b1; be1 = be; wd1 = d; end
        else       begin we0 = 1'b1; be0 = be; wd0 = d; end
        @(posedge clk);
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        we0 = 0; be0 = 0; wd0 = 0;
        we1 = 0; be1 = 0; wd1 = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 u0 rd", rd0, 32'h0);
        check("R1 u1 rd", rd1, 32'h0);
        check("R1 pads", {30'h0, cp0, dp0, cp1, dp1} >> 0, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk on the masked copy
        for (int i = 0; i < NV; i++) begin
            hold0 = TBL[i].hold;
            wr(1'b0, TBL[i].be, TBL[i].data);
            repeat (5) @(negedge clk);
            check($sformatf("R2/R9-R11 pads vec%0d", i), {30'h0, cp0, dp0}, {30'h0, TBL[i].pads});
            check($sformatf("R3-R7 rd vec%0d", i), rd0, TBL[i].rd);
        end
        hold0 = 1'b0;

        // R6 R8: capture latency on the plain copy, any write updates
        wr(1'b1, 4'b1000, 32'h0000_0000);   // now just after edge k
        check("R6 rd at k", rd1, 32'h0);
        @(negedge clk);
        check("R6 rd at k+1", rd1, 32'h0);
        @(negedge clk);
        check("R6 rd at k+2", rd1, 32'h0);
        @(negedge clk);
        check("R6 R8 R3 rd at k+3", rd1, 32'h0000_0300);

        // R8 R2: enables with drive low pull both pads
        wr(1'b1, 4'b1111, 32'h0003_0000);
        check("R8 R2 pads", {30'h0, cp1, dp1}, 32'h3);
        repeat (4) @(negedge clk);
        check("R8 R2 rd", rd1, 32'h0003_0000);

        // R5: junk in 11:8 discarded, released lines read high
        wr(1'b1, 4'b1111, 32'h0003_0F03);
        repeat (4) @(negedge clk);
        check("R5 rd", rd1, 32'h0003_0303);
        check("R2 pads released", {30'h0, cp1, dp1}, 32'h0);

        // R4: device holds data low while master releases it
        hold1 = 1'b1;
        wr(1'b1, 4'b0001, 32'h0000_0003);
        repeat (4) @(negedge clk);
        check("R4 held data", rd1, 32'h0003_0203);
        hold1 = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule